// File: doc/BRIEF.md
# Stored Register Bank with Timed Write Cycle

This block holds the stored settings of a two-channel digitally controlled position device: four 6-bit registers per channel, eight in all, standing in for nonvolatile cells. A bus slave in front of it decodes the commands and hands over store commands. Three kinds of store exist: a host write of a data byte into one register, a save of one channel's current position into one of that channel's registers, and a global save that copies every channel's position into the register with the same pointer in each channel. A store is only held pending when the command arrives. It is applied when the bus stop condition that closes the command is seen. The bank then runs a timed write cycle. During that cycle a busy flag is raised, which the bus slave uses to withhold its address acknowledge, and any further command is ignored.

A write-protect input, active low, vetoes every store. A store command that arrives while protection is active is dropped: the bus handshake still completes elsewhere, but no register changes and no busy cycle starts. Protection that becomes active between the command and the stop also drops the pending store. Reads are combinational and return the stored value at any time. Register 0 of every channel is brought out at all times as the power-up position of that channel. Reset loads the cells from a parameter that models the retained contents. The write-cycle length is a parameter counted in clock cycles.

The sequencer has three states. ST_IDLE goes to ST_ARMED when a store is accepted. ST_ARMED goes to ST_BURN on a stop with protection off. It goes to ST_IDLE on a stop with protection on, or on a store command with protection on. It stays in ST_ARMED and replaces the pending store when a new store is accepted. ST_BURN goes back to ST_IDLE after the programmed number of cycles.

Top module: `stbank`

## Requirements
- R1: After reset every register reads the value of its slice of INIT_VAL. Register (channel c, pointer p) occupies bits [(c*4+p)*6 +: 6]. busy is 0.
- R2: boot_pos[c*6 +: 6] always equals register 0 of channel c, including after a store into that register.
- R3: A store changes no register and does not raise busy before a bus_stop pulse. A bus_stop with no pending store does nothing.
- R4: On the clock edge that samples bus_stop with a store pending and wp_n high, the target register is written, and busy is 1 from the next cycle.
- R5: busy stays high for exactly WR_CYCLES clock cycles, then falls.
- R6: While busy is high, cmd_valid and bus_stop are ignored. Commands given during busy change no register after busy falls.
- R7: cmd_op 2'b00 writes cmd_data into (cmd_chan, cmd_ptr). cmd_op 2'b01 saves that channel's pos_in slice as sampled on the command cycle, not on the stop cycle.
- R8: cmd_op 2'b10 saves every channel's pos_in slice into the register at cmd_ptr of that channel. cmd_chan is ignored.
- R9: With wp_n low on the command cycle or on the stop cycle, no register changes and busy stays 0.
- R10: A later accepted store replaces an earlier pending one before the stop. Only the last store is applied.
- R11: cmd_op 2'b11 is reserved and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect, low blocks all stores |
| cmd_valid | input | 1 | One-cycle strobe of a decoded store command |
| cmd_op | input | 2 | 00 write, 01 save one channel, 10 save all, 11 reserved |
| cmd_chan | input | 1 | Target channel |
| cmd_ptr | input | 2 | Target register pointer |
| cmd_data | input | 6 | Data for a host write |
| pos_in | input | 12 | Current positions, channel c at [c*6 +: 6] |
| bus_stop | input | 1 | One-cycle strobe at the bus stop condition |
| rd_chan | input | 1 | Read channel |
| rd_ptr | input | 2 | Read register pointer |
| rd_data | output | 6 | Stored value at (rd_chan, rd_ptr) |
| boot_pos | output | 12 | Register 0 of each channel, channel c at [c*6 +: 6] |
| busy | output | 1 | Write cycle in progress, address not acknowledged |

## Verification
A sequencer stuck in ST_ARMED or entered too early shows up as a register change on rd_data or a busy rise one cycle after a stop or command that should not cause it. A corrupt pending store shows up as a wrong value on rd_data in the cycle after the stop. A wrong timer count shows up as busy falling on the wrong cycle, WR_CYCLES cycles after the commit. A leak through write protect or through the busy window shows up on the read port as soon as busy falls. The reads scan every register after each scenario, so a write to a cell the command did not target is also caught.

// File: rtl/stbank_pkg.sv
package stbank_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SAVE  = 2'b01,
        OP_GSAVE = 2'b10,
        OP_RSVD  = 2'b11
    } store_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/stbank_seq.sv
module stbank_seq #(
    parameter int WR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_store,
    input  logic wp_n,
    input  logic bus_stop,
    output logic capture,
    output logic commit,
    output logic busy
);
    import stbank_pkg::*;

    localparam int CW = $clog2(WR_CYCLES + 1);

    seq_state_e state, state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_store && wp_n) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (bus_stop)                state_nx = wp_n ? ST_BURN : ST_IDLE;
                else if (cmd_store && !wp_n) state_nx = ST_IDLE;
            end
            ST_BURN:  if (cnt == '0) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_IDLE:  capture = cmd_store && wp_n;
            ST_ARMED: begin
                capture = cmd_store && wp_n && !bus_stop;
                commit  = bus_stop && wp_n;
            end
            ST_BURN:  busy = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (commit)                     cnt <= CW'(WR_CYCLES - 1);
        else if (state == ST_BURN && cnt != '0) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/stbank_array.sv
module stbank_array #(
    parameter int NCH  = 2,
    parameter int NREG = 4,
    parameter int W    = 6,
    parameter logic [NCH*NREG*W-1:0] INIT_VAL = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic                          commit,
    input  stbank_pkg::store_op_e         cmd_op,
    input  logic [$clog2(NCH)-1:0]        cmd_chan,
    input  logic [$clog2(NREG)-1:0]       cmd_ptr,
    input  logic [W-1:0]                  cmd_data,
    input  logic [NCH*W-1:0]              pos_in,
    input  logic [$clog2(NCH)-1:0]        rd_chan,
    input  logic [$clog2(NREG)-1:0]       rd_ptr,
    output logic [W-1:0]                  rd_data,
    output logic [NCH*W-1:0]              boot_pos
);
    import stbank_pkg::*;

    localparam int CHW = $clog2(NCH);
    localparam int PW  = $clog2(NREG);
    localparam int NCELL = NCH * NREG;

    store_op_e        pend_op;
    logic [CHW-1:0]   pend_chan;
    logic [PW-1:0]    pend_ptr;
    logic [W-1:0]     pend_data;
    logic [NCH*W-1:0] pend_pos;
    logic [NCELL*W-1:0] flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_op   <= OP_WRITE;
            pend_chan <= '0;
            pend_ptr  <= '0;
            pend_data <= '0;
            pend_pos  <= '0;
        end else if (capture) begin
            pend_op   <= cmd_op;
            pend_chan <= cmd_chan;
            pend_ptr  <= cmd_ptr;
            pend_data <= cmd_data;
            pend_pos  <= pos_in;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            logic [W-1:0] q;
            logic         hit;
            logic [W-1:0] nv;

            always_comb begin
                hit = 1'b0;
                nv  = pend_pos[c*W +: W];
                unique case (pend_op)
                    OP_WRITE: begin
                        hit = (pend_chan == CHW'(c)) && (pend_ptr == PW'(r));
                        nv  = pend_data;
                    end
                    OP_SAVE:  hit = (pend_chan == CHW'(c)) && (pend_ptr == PW'(r));
                    OP_GSAVE: hit = (pend_ptr == PW'(r));
                    default:  hit = 1'b0;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             q <= INIT_VAL[(c*NREG+r)*W +: W];
                else if (commit && hit) q <= nv;
            end

            assign flat[(c*NREG+r)*W +: W] = q;
        end
        assign boot_pos[c*W +: W] = g_ch[c].g_reg[0].q;
    end

    logic [CHW+PW-1:0] rd_idx;
    assign rd_idx  = {rd_chan, rd_ptr};
    assign rd_data = flat[rd_idx*W +: W];
endmodule

// File: rtl/stbank.sv
module stbank #(
    parameter int NCH       = 2,
    parameter int NREG      = 4,
    parameter int W         = 6,
    parameter int WR_CYCLES = 50000,
    parameter logic [NCH*NREG*W-1:0] INIT_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wp_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [$clog2(NCH)-1:0]  cmd_chan,
    input  logic [$clog2(NREG)-1:0] cmd_ptr,
    input  logic [W-1:0]            cmd_data,
    input  logic [NCH*W-1:0]        pos_in,
    input  logic                    bus_stop,
    input  logic [$clog2(NCH)-1:0]  rd_chan,
    input  logic [$clog2(NREG)-1:0] rd_ptr,
    output logic [W-1:0]            rd_data,
    output logic [NCH*W-1:0]        boot_pos,
    output logic                    busy
);
    import stbank_pkg::*;

    store_op_e op;
    logic      cmd_store;
    logic      capture;
    logic      commit;

    assign op        = store_op_e'(cmd_op);
    assign cmd_store = cmd_valid && (op != OP_RSVD);

    stbank_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_store(cmd_store),
        .wp_n     (wp_n),
        .bus_stop (bus_stop),
        .capture  (capture),
        .commit   (commit),
        .busy     (busy)
    );

    stbank_array #(
        .NCH(NCH), .NREG(NREG), .W(W), .INIT_VAL(INIT_VAL)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .commit  (commit),
        .cmd_op  (op),
        .cmd_chan(cmd_chan),
        .cmd_ptr (cmd_ptr),
        .cmd_data(cmd_data),
        .pos_in  (pos_in),
        .rd_chan (rd_chan),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data),
        .boot_pos(boot_pos)
    );
endmodule

// File: rtl/stbank_chk.sv
module stbank_chk #(
    parameter int NCH       = 2,
    parameter int NREG      = 4,
    parameter int W         = 6,
    parameter int WR_CYCLES = 50000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wp_n,
    input logic                    bus_stop,
    input logic [$clog2(NCH)-1:0]  rd_chan,
    input logic [$clog2(NREG)-1:0] rd_ptr,
    input logic [W-1:0]            rd_data,
    input logic [NCH*W-1:0]        boot_pos,
    input logic                    busy
);
    int unsigned run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    // R4, R9: busy only starts right after an unprotected stop
    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_stop) && $past(wp_n)));

    // R5: busy window never exceeds WR_CYCLES
    p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < WR_CYCLES));

    // R5: busy window is exactly WR_CYCLES long
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == WR_CYCLES));

    // R3, R6: registers only change together with the start of a write cycle
    p_no_silent_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(busy) && $stable(rd_chan) && $stable(rd_ptr)) |-> $stable(rd_data));

    // R9: protection blocks the commit edge
    p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wp_n) && $stable(rd_chan) && $stable(rd_ptr)) |-> $stable(rd_data));

    // R2: boot position mirrors register 0
    p_boot_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == '0) |-> (rd_data == boot_pos[rd_chan*W +: W]));
endmodule

bind stbank stbank_chk #(
    .NCH(NCH), .NREG(NREG), .W(W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .bus_stop(bus_stop),
    .rd_chan (rd_chan),
    .rd_ptr  (rd_ptr),
    .rd_data (rd_data),
    .boot_pos(boot_pos),
    .busy    (busy)
);

// File: tb/stbank_tb.sv
`timescale 1ns/1ps
module stbank_tb;
    localparam int WRC = 8;

    function automatic logic [47:0] mk_init();
        logic [47:0] v;
        for (int i = 0; i < 8; i++) v[i*6 +: 6] = 6'((i * 7 + 3) % 64);
        return v;
    endfunction
    localparam logic [47:0] INIT = mk_init();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_chan = 1'b0;
    logic [1:0] cmd_ptr = 2'b00;
    logic [5:0] cmd_data = 6'd0;
    logic [11:0] pos_in = 12'd0;
    logic bus_stop = 1'b0;
    logic rd_chan = 1'b0;
    logic [1:0] rd_ptr = 2'b00;
    logic [5:0] rd_data;
    logic [11:0] boot_pos;
    logic busy;

    int errors = 0;
    int checks = 0;
    logic [5:0] exp_mem [8];

    always #2.5 clk = ~clk;

    stbank #(.WR_CYCLES(WRC), .INIT_VAL(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_ptr(cmd_ptr),
        .cmd_data(cmd_data), .pos_in(pos_in), .bus_stop(bus_stop),
        .rd_chan(rd_chan), .rd_ptr(rd_ptr), .rd_data(rd_data),
        .boot_pos(boot_pos), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic scan_all(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_chan = i[2];
            rd_ptr  = i[1:0];
            #0.1;
            chk(req, int'(rd_data), int'(exp_mem[i]));
        end
        chk({req, " boot0"}, int'(boot_pos[5:0]), int'(exp_mem[0]));
        chk({req, " boot1"}, int'(boot_pos[11:6]), int'(exp_mem[4]));
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic ch, input logic [1:0] p, input logic [5:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_ptr = p; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) exp_mem[i] = INIT[i*6 +: 6];
        chk("R1 busy after reset", int'(busy), 0);
        scan_all("R1 R2 reset");
    endtask

    task automatic t_write();
        int n;
        send_cmd(2'b00, 1'b1, 2'd2, 6'h2A);
        repeat (3) @(negedge clk);
        chk("R3 busy before stop", int'(busy), 0);
        scan_all("R3 no change before stop");
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        exp_mem[6] = 6'h2A;
        chk("R4 busy after stop", int'(busy), 1);
        scan_all("R4 R7 write applied");
        n = 0;
        for (int i = 0; i < 50 && busy; i++) begin n++; @(negedge clk); end
        chk("R5 busy length", n, WRC);
    endtask

    task automatic t_busy_ignore();
        send_cmd(2'b00, 1'b0, 2'd1, 6'h11);
        send_stop();
        exp_mem[1] = 6'h11;
        send_cmd(2'b00, 1'b0, 2'd3, 6'h3C);
        send_stop();
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R6 busy after ignored cmd", int'(busy), 0);
        scan_all("R6 busy ignore");
    endtask

    task automatic t_save();
        pos_in = {6'h07, 6'h15};
        send_cmd(2'b01, 1'b0, 2'd3, 6'h00);
        pos_in = {6'h09, 6'h2F};
        send_stop();
        exp_mem[3] = 6'h15;
        scan_all("R7 save snapshot");
        wait_idle();
    endtask

    task automatic t_gsave();
        pos_in = {6'h33, 6'h0E};
        send_cmd(2'b10, 1'b1, 2'd0, 6'h3F);
        send_stop();
        exp_mem[0] = 6'h0E;
        exp_mem[4] = 6'h33;
        chk("R8 busy", int'(busy), 1);
        scan_all("R8 R2 global save");
        wait_idle();
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        send_cmd(2'b00, 1'b1, 2'd1, 6'h05);
        wp_n = 1'b1;
        send_stop();
        chk("R9 wp at command busy", int'(busy), 0);
        scan_all("R9 wp at command");
        send_cmd(2'b00, 1'b1, 2'd1, 6'h06);
        wp_n = 1'b0;
        send_stop();
        chk("R9 wp at stop busy", int'(busy), 0);
        wp_n = 1'b1;
        scan_all("R9 wp at stop");
        send_stop();
        chk("R3 stop without pending", int'(busy), 0);
    endtask

    task automatic t_replace();
        send_cmd(2'b00, 1'b0, 2'd2, 6'h21);
        send_cmd(2'b00, 1'b1, 2'd3, 6'h12);
        send_stop();
        exp_mem[7] = 6'h12;
        scan_all("R10 last store wins");
        wait_idle();
    endtask

    task automatic t_reserved();
        send_cmd(2'b11, 1'b0, 2'd2, 6'h1D);
        send_stop();
        chk("R11 reserved busy", int'(busy), 0);
        scan_all("R11 reserved op");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_write();
                t_busy_ignore();
                t_save();
                t_gsave();
                t_wp();
                t_replace();
                t_reserved();
            end
            begin
                repeat (20000) @(negedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule